// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster strobes for a flat panel: horizontal sync, vertical sync, data enable and a pixel-clock enable that marks the system-clock cycles on which a pixel is shifted out. Software sets up the line and frame geometry, the pixel clock divisor, the panel type and an output polarity field through a small register port. Setting the run bit then starts the raster at the first sync pixel of a frame.

Clearing the run bit does not stop the raster at once. The block finishes the frame in progress, drives every strobe low, and raises a frame-finished flag. Two sticky error flags record a pixel that was missing while data enable was high, and a geometry word rewritten while the raster was running. Both flags clear only when the run bit is written low.

Top module: `lcd_raster_timing`

## Requirements
- R1: After reset, pclk_en, hsync, vsync and de are low, and all four register words read as zero.
- R2: The line word at address 1 holds active pixels minus one in bits 9:0, sync width minus one in bits 15:10, front porch minus one in bits 23:16 and back porch minus one in bits 31:24, and it reads back as written. Each line is laid out in this order: sync, then back porch, then active pixels, then front porch.
- R3: The frame word at address 2 holds active lines minus one in bits 9:0 and sync width minus one in bits 15:10. Its front porch (bits 23:16) and back porch (bits 31:24) are counted as stored, and zero is allowed. The line counter advances once per completed line, and the frame runs sync lines, then back porch, then active lines, then front porch.
- R4: de is high for exactly those pixels that fall inside both the active pixels of a line and the active lines of a frame.
- R5: pclk_en pulses once every D system clocks. D is the 8-bit divisor in bits 7:0 of address 3, raised to 2 when the TFT bit is set and to 3 when it is clear.
- R6: Address 0 holds the run bit in bit 0 and the TFT bit in bit 1. Writing the run bit high while the raster is stopped starts a frame, and the first pixel of that frame has both sync strobes active.
- R7: When the run bit is written low, the raster completes its current frame and then stops with all strobes low. The frame-finished flag (address 0, bit 8) is then set, and writing the run bit high clears it.
- R8: A pixel strobe with de high and pix_valid low sets the underflow flag (address 0, bit 9). The flag survives a write that sets the run bit and is cleared only by writing the run bit low.
- R9: Writing address 1 or 2 while the raster is running sets the sync-lost flag (address 0, bit 10), and writing it while stopped does not. The flag is cleared by writing the run bit low.
- R10: Address 3 keeps bits 25:20 and 15:0 and reads zero elsewhere. While the raster runs, bit 20 inverts hsync, bit 21 inverts vsync and bit 22 inverts de. When stopped, all strobes are low whatever the polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| pix_valid | input | 1 | Pixel source has data for the current pixel |
| pclk_en | output | 1 | One-cycle pixel strobe |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |

## Verification
The assertions assume a few things about the inputs. Reset is held low before the first clock. Write addresses are always known. The effective divisor is never below 2, which makes back-to-back pixel strobes impossible. The stimulus changes inputs only on falling clock edges. It programs geometry and divisor only while the raster is stopped, except in the sync-lost case, where the line word is rewritten with its current value so that the frame in progress is not disturbed. Each frame is measured at the ports: the bench counts strobes, sync and enable pixels, the position of the first enabled pixel, and the clock span from the first pixel to the last.

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing #(
  parameter int CW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        pix_valid,
  output logic        pclk_en,
  output logic        hsync,
  output logic        vsync,
  output logic        de
);
  localparam logic [31:0] CFG_MASK = 32'h03F0_FFFF;
  localparam int DW = 8;

  logic          run, ctl_en, ctl_tft, done_q, uflow, slost;
  logic [31:0]   hreg, vreg, creg;
  logic [CW-1:0] hcnt, vcnt;
  logic [DW-1:0] divcnt;

  logic [CW-1:0] h_sw, h_bp, h_act, h_fp, h_as, h_fs, h_tot;
  logic [CW-1:0] v_sw, v_bp, v_act, v_fp, v_as, v_fs, v_tot;
  assign h_sw  = CW'(hreg[15:10]) + CW'(1);
  assign h_act = CW'(hreg[9:0])   + CW'(1);
  assign h_fp  = CW'(hreg[23:16]) + CW'(1);
  assign h_bp  = CW'(hreg[31:24]) + CW'(1);
  assign v_sw  = CW'(vreg[15:10]) + CW'(1);
  assign v_act = CW'(vreg[9:0])   + CW'(1);
  assign v_fp  = CW'(vreg[23:16]);
  assign v_bp  = CW'(vreg[31:24]);
  assign h_as  = h_sw + h_bp;
  assign h_fs  = h_as + h_act;
  assign h_tot = h_fs + h_fp;
  assign v_as  = v_sw + v_bp;
  assign v_fs  = v_as + v_act;
  assign v_tot = v_fs + v_fp;

  logic h_last, v_last;
  assign h_last = hcnt >= h_tot - CW'(1);
  assign v_last = vcnt >= v_tot - CW'(1);

  logic [DW-1:0] div_min, div_eff;
  assign div_min = ctl_tft ? DW'(2) : DW'(3);
  assign div_eff = (creg[DW-1:0] < div_min) ? div_min : creg[DW-1:0];
  assign pclk_en = run && (divcnt >= div_eff - DW'(1));

  logic ctl_wr, en_next, start;
  assign ctl_wr  = wr_en && (wr_addr == 2'd0);
  assign en_next = ctl_wr ? wr_data[0] : ctl_en;
  assign start   = !run && ctl_wr && wr_data[0];

  logic hs_raw, vs_raw, de_raw;
  assign hs_raw = hcnt < h_sw;
  assign vs_raw = vcnt < v_sw;
  assign de_raw = (hcnt >= h_as) && (hcnt < h_fs) && (vcnt >= v_as) && (vcnt < v_fs);

  assign hsync = run && (hs_raw ^ creg[20]);
  assign vsync = run && (vs_raw ^ creg[21]);
  assign de    = run && (de_raw ^ creg[22]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;  hcnt <= '0;  vcnt <= '0;  divcnt <= '0;
      ctl_en <= 1'b0;  ctl_tft <= 1'b0;
      hreg <= '0;  vreg <= '0;  creg <= '0;
      done_q <= 1'b0;  uflow <= 1'b0;  slost <= 1'b0;
    end else begin
      if (start) begin
        run <= 1'b1;  hcnt <= '0;  vcnt <= '0;  divcnt <= '0;
      end else if (run) begin
        if (pclk_en) begin
          divcnt <= '0;
          if (h_last) begin
            hcnt <= '0;
            if (v_last) begin
              vcnt <= '0;
              if (!en_next) begin
                run    <= 1'b0;
                done_q <= 1'b1;
              end
            end else begin
              vcnt <= vcnt + CW'(1);
            end
          end else begin
            hcnt <= hcnt + CW'(1);
          end
        end else begin
          divcnt <= divcnt + DW'(1);
        end
      end
      if (pclk_en && de_raw && !pix_valid) uflow <= 1'b1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            ctl_en  <= wr_data[0];
            ctl_tft <= wr_data[1];
            if (wr_data[0]) done_q <= 1'b0;
            else begin
              uflow <= 1'b0;
              slost <= 1'b0;
            end
          end
          2'd1: begin
            hreg <= wr_data;
            if (run) slost <= 1'b1;
          end
          2'd2: begin
            vreg <= wr_data;
            if (run) slost <= 1'b1;
          end
          default: creg <= wr_data & CFG_MASK;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {21'd0, slost, uflow, done_q, 6'd0, ctl_tft, ctl_en};
      2'd1:    rd_data = hreg;
      2'd2:    rd_data = vreg;
      default: rd_data = creg;
    endcase
  end

  a_r5_pclk_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_en |=> !pclk_en);
  a_r6_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run && hsync == !creg[20] && vsync == !creg[21]));
  a_r7_stop_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> done_q);
  a_r7_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(pclk_en && h_last && v_last));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(hsync || vsync || de || pclk_en));
  a_r8_uflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !(ctl_wr && !wr_data[0])) |=> uflow);
  a_r9_slost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (slost && !(ctl_wr && !wr_data[0])) |=> slost);
endmodule

// File: tb/tb_lcd_raster_timing.sv
`timescale 1ns/1ps
module tb_lcd_raster_timing;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        pix_valid = 1'b1;
  logic        pclk_en, hsync, vsync, de;

  lcd_raster_timing dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix_valid(pix_valid),
    .pclk_en(pclk_en), .hsync(hsync), .vsync(vsync), .de(de)
  );

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  // div, tft, hact, hsw, hfp, hbp, vact, vsw, vfp, vbp (one byte each)
  localparam logic [79:0] VEC [6] = '{
    80'h00_01_04_02_02_03_03_01_01_02,
    80'h00_00_04_02_02_03_03_01_01_02,
    80'h01_01_05_01_01_01_02_02_00_00,
    80'h05_00_03_03_04_02_04_01_02_01,
    80'h02_00_08_01_01_01_01_01_00_00,
    80'h04_01_02_01_01_01_02_03_03_03
  };

  bit mon_on = 0;
  int cyc, npix, nde, nhs, nvs, fst, lst, fde, fhs, fvs;
  bit de_seen;

  always @(negedge clk) if (mon_on) begin
    cyc++;
    if (pclk_en) begin
      if (npix == 0) begin fst = cyc; fhs = hsync; fvs = vsync; end
      lst = cyc;
      if (de && !de_seen) begin de_seen = 1; fde = npix; end
      npix++;
      nde += de;
      nhs += hsync;
      nvs += vsync;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic mon_clear();
    cyc = 0; npix = 0; nde = 0; nhs = 0; nvs = 0;
    fst = 0; lst = 0; fde = -1; fhs = 0; fvs = 0; de_seen = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!rd_data[8] && n < 50000) begin
      @(negedge clk);
      n++;
    end
    chk("R7 frame-finished flag reached", int'(rd_data[8]), 1);
  endtask

  task automatic run_frame(input logic tft);
    mon_clear();
    mon_on = 1;
    wr(2'd0, {30'd0, tft, 1'b1});
    wr(2'd0, {30'd0, tft, 1'b0});
    wait_done();
    mon_on = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] hw, vw, h1;
    int dv, tf, ha, hs, hf, hb, va, vs, vf, vb, ht, vt, eff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pclk_en", int'(pclk_en), 0);
    chk("R1 hsync", int'(hsync), 0);
    chk("R1 vsync", int'(vsync), 0);
    chk("R1 de", int'(de), 0);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      chk("R1 register reset", int'(rd_data), 0);
    end
    rd_addr = 2'd0;

    // Vector table: one frame per geometry
    for (int i = 0; i < 6; i++) begin
      dv = int'(VEC[i][79:72]); tf = int'(VEC[i][71:64]);
      ha = int'(VEC[i][63:56]); hs = int'(VEC[i][55:48]);
      hf = int'(VEC[i][47:40]); hb = int'(VEC[i][39:32]);
      va = int'(VEC[i][31:24]); vs = int'(VEC[i][23:16]);
      vf = int'(VEC[i][15:8]);  vb = int'(VEC[i][7:0]);
      hw = ((hb - 1) << 24) | ((hf - 1) << 16) | ((hs - 1) << 10) | (ha - 1);
      vw = (vb << 24) | (vf << 16) | ((vs - 1) << 10) | (va - 1);
      wr(2'd1, hw);
      wr(2'd2, vw);
      wr(2'd3, dv);
      run_frame(tf[0]);
      ht = hs + hb + ha + hf;
      vt = vs + vb + va + vf;
      eff = (dv < (tf != 0 ? 2 : 3)) ? (tf != 0 ? 2 : 3) : dv;
      chk("R3 pixels per frame", npix, ht * vt);
      chk("R4 enabled pixels", nde, ha * va);
      chk("R2 hsync pixels", nhs, hs * vt);
      chk("R3 vsync pixels", nvs, vs * ht);
      chk("R2 first enabled pixel index", fde, (vs + vb) * ht + hs + hb);
      chk("R5 strobe span", lst - fst, (ht * vt - 1) * eff);
      chk("R6 first pixel in both syncs", fhs & fvs, 1);
    end
    chk("R8 no underflow with valid pixels", int'(rd_data[9]), 0);

    // R5 maximum divisor, all-zero geometry (4 x 2 pixels)
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    wr(2'd3, 32'd255);
    run_frame(1'b0);
    chk("R5 divisor 255 span", lst - fst, 7 * 255);
    chk("R3 zero porches frame size", npix, 8);

    // R7 graceful stop mid frame: 77-pixel frame, divisor 2
    h1 = (32'd2 << 24) | (32'd1 << 16) | (32'd1 << 10) | 32'd3;
    wr(2'd1, h1);
    wr(2'd2, (32'd2 << 24) | (32'd1 << 16) | 32'd2);
    wr(2'd3, 32'd0);
    mon_clear();
    mon_on = 1;
    wr(2'd0, 32'd3);
    chk("R7 enable clears finished flag", int'(rd_data[8]), 0);
    repeat (200) @(negedge clk);
    wr(2'd0, 32'd2);
    chk("R7 still running after disable", int'(rd_data[8]), 0);
    wait_done();
    mon_on = 0;
    chk("R7 frame completed before stop", npix, 154);
    chk("R7 strobes low when stopped", int'(hsync | vsync | de | pclk_en), 0);

    // R8 underflow
    pix_valid = 1'b0;
    run_frame(1'b1);
    pix_valid = 1'b1;
    chk("R8 underflow set", int'(rd_data[9]), 1);
    wr(2'd0, 32'd3);
    chk("R8 underflow kept on enable", int'(rd_data[9]), 1);
    wr(2'd0, 32'd2);
    chk("R8 underflow cleared by disable", int'(rd_data[9]), 0);
    wait_done();

    // R9 sync lost
    wr(2'd1, h1);
    chk("R9 idle write no sync-lost", int'(rd_data[10]), 0);
    wr(2'd0, 32'd3);
    wr(2'd1, h1);
    chk("R9 running write sets sync-lost", int'(rd_data[10]), 1);
    wr(2'd0, 32'd2);
    chk("R9 sync-lost cleared by disable", int'(rd_data[10]), 0);
    wait_done();

    // R10 polarity
    wr(2'd3, 32'h0010_0000);
    run_frame(1'b1);
    chk("R10 inverted hsync pixels", nhs, 9 * 7);
    chk("R10 vsync unaffected", nvs, 11);
    chk("R10 idle hsync low despite inversion", int'(hsync), 0);

    // R10 / R2 readback
    wr(2'd3, 32'hFFFF_FFFF);
    rd_addr = 2'd3;
    #1;
    chk("R10 config readback mask", int'(rd_data), int'(32'h03F0_FFFF));
    rd_addr = 2'd1;
    #1;
    chk("R2 line word readback", int'(rd_data), int'(h1));
    rd_addr = 2'd0;

    finished = 1;
    summary();
  end
endmodule